// File: doc/BRIEF.md
# AXI Write Job Issuer with Response Check

This block turns write jobs into AXI4 write traffic. A job gives a start address, a length in bytes and a transaction ID. Each accepted job becomes one address-write (AW) transaction. The write bytes arrive one per cycle on a separate byte stream. The block packs them into data-write (W) beats in little-endian lane order. When a burst's length is not a whole number of bus words, the final beat carries a partial strobe. Every issued AW queues its ID, and each write response (B) is checked against that queue in issue order. Any mismatch sets a sticky error flag.

The block has two data modes, chosen by `hold_mode`.

- **Lead mode** (`hold_mode` = 0): bytes flow onto W as soon as they arrive, even before their job exists. A marker on the last byte closes each burst. The beat count of each finished burst is later compared with the beat count of the matching job.
- **Hold mode** (`hold_mode` = 1): this is an AXI3-style ordering. No byte is taken until the AW for its burst has been issued. The job's byte length then decides where the burst ends.

Top module: `axi_wjob_issuer`

## Requirements
- R1: After reset, awvalid, wvalid and err are 0, and job_ready is 1.
- R2: An accepted job is presented on AW with these fields, held stable until awready:
  - awaddr equal to the job address and awid equal to the job ID.
  - awlen = ceil(length/BYTES)-1, where BYTES = DATA_W/8.
  - awsize = log2(BYTES) and awburst = 2'b01 (incrementing).
- R3: Only one job is in flight on AW at a time. job_ready stays 0 while awvalid is 1.
- R4: Burst byte k is placed in lane (k mod BYTES) of beat (k div BYTES). Lane j occupies wdata bits [8j+7:8j].
- R5: Every beat other than the last has all strobe bits set. The last beat's strobe has exactly the low (length mod BYTES) bits set, or all bits when that value is 0. Unused lanes carry zero data.
- R6: wlast is 1 on the final beat of each burst and 0 on every other beat.
- R7: While wvalid is 1 and wready is 0, wvalid, wdata, wstrb and wlast hold their values, and byte_ready is 0.
- R8: In lead mode, bytes are accepted and W beats are emitted before the burst's job arrives. A burst ends at the byte that has byte_last set.
- R9: In hold mode:
  - byte_ready stays 0 and no W beat appears until the AW for that burst has completed.
  - byte_last is ignored; the burst ends after the job's byte-length count of bytes.
- R10: In lead mode, if a finished burst's beat count differs from its job's beat count, err is set.
- R11: A B response sets err when its bid differs from the oldest outstanding awid, or when bresp is not 2'b00. Once set, err stays set until reset. Matching OKAY responses leave err at 0.
- R12: A B response that arrives with no outstanding AW sets err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_mode | input | 1 | 1 = hold W until its AW is issued; change only while idle |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Job accepted when both valid and ready |
| job_addr | input | 32 | Bus-aligned start address |
| job_len | input | 12 | Burst length in bytes, at least 1 |
| job_id | input | 4 | Transaction ID |
| byte_valid | input | 1 | Write byte offered |
| byte_ready | output | 1 | Write byte accepted |
| byte_data | input | 8 | Write byte |
| byte_last | input | 1 | Last byte of burst (lead mode only) |
| awvalid | output | 1 | AW valid |
| awready | input | 1 | AW ready |
| awaddr | output | 32 | AW address |
| awlen | output | 8 | AW beats minus one |
| awsize | output | 3 | AW beat size, log2 of bytes |
| awburst | output | 2 | AW burst type |
| awid | output | 4 | AW ID |
| wvalid | output | 1 | W valid |
| wready | input | 1 | W ready |
| wdata | output | DATA_W | W data |
| wstrb | output | DATA_W/8 | W byte strobes |
| wlast | output | 1 | Final beat of burst |
| bvalid | input | 1 | B valid |
| bready | output | 1 | B ready, always 1 |
| bid | input | 4 | B ID |
| bresp | input | 2 | B response code |
| err | output | 1 | Sticky protocol/response error |

## Verification
The assertions make several assumptions about the environment:
- hold_mode changes only right after reset.
- Job lengths are non-zero and small enough that awlen fits in 8 bits.
- At most FIFO_DEPTH responses and bursts are ever outstanding.

The hold-mode ordering check relies on the AW and W handshake counts starting together at reset. The bench therefore resets before every scenario. It selects the mode only while reset is held, and it never issues more than two jobs before their responses.

// File: rtl/axi_wjob_pkg.sv
package axi_wjob_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 12;
    localparam int ID_W   = 4;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [ID_W-1:0]   id;
    } wjob_t;

    // number of bus words covering len bytes, with 2**lg bytes per word
    function automatic logic [LEN_W-1:0] beats_of(input logic [LEN_W-1:0] len,
                                                  input int lg);
        logic [LEN_W:0] sum;
        sum = {1'b0, len} + (LEN_W+1)'((1 << lg) - 1);
        return LEN_W'(sum >> lg);
    endfunction

endpackage

// File: rtl/wjob_fifo.sv
module wjob_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == (PW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/wjob_packer.sv
module wjob_packer
    import axi_wjob_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_mode,
    input  logic              len_known,
    input  logic [LEN_W-1:0]  head_len,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [7:0]        byte_data,
    input  logic              byte_last,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic              wlast,
    output logic              burst_done,
    output logic [LEN_W-1:0]  burst_beats
);
    localparam int BYTES = DATA_W / 8;
    localparam int LW    = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic [LW-1:0]    lane;
    logic [LEN_W-1:0] bcnt;
    logic [LEN_W-1:0] beats;
    logic             take, end_b, word_full;

    assign byte_ready  = !wvalid && (!hold_mode || len_known);
    assign take        = byte_valid && byte_ready;
    assign end_b       = hold_mode ? (bcnt == head_len - 1'b1) : byte_last;
    assign word_full   = (lane == LW'(BYTES - 1));
    assign burst_done  = take && end_b;
    assign burst_beats = beats + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wvalid <= 1'b0;
            wdata  <= '0;
            wstrb  <= '0;
            wlast  <= 1'b0;
            lane   <= '0;
            bcnt   <= '0;
            beats  <= '0;
        end else if (wvalid) begin
            if (wready) begin
                wvalid <= 1'b0;
                wdata  <= '0;
                wstrb  <= '0;
                wlast  <= 1'b0;
            end
        end else if (take) begin
            wdata[lane*8 +: 8] <= byte_data;
            wstrb[lane]        <= 1'b1;
            bcnt               <= end_b ? '0 : bcnt + 1'b1;
            if (end_b || word_full) begin
                wvalid <= 1'b1;
                wlast  <= end_b;
                lane   <= '0;
                beats  <= end_b ? '0 : beats + 1'b1;
            end else begin
                lane   <= lane + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wjob_bcheck.sv
module wjob_bcheck
    import axi_wjob_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exp_push,
    input  logic [ID_W-1:0] exp_id,
    output logic            exp_full,
    input  logic            bvalid,
    input  logic [ID_W-1:0] bid,
    input  logic [1:0]      bresp,
    output logic            b_err
);
    logic [ID_W-1:0] head_id;
    logic            exp_empty;

    wjob_fifo #(.W(ID_W), .DEPTH(DEPTH)) u_idq (
        .clk(clk), .rst(rst),
        .push(exp_push), .din(exp_id),
        .pop(bvalid), .dout(head_id),
        .full(exp_full), .empty(exp_empty)
    );

    always_comb begin
        b_err = 1'b0;
        if (bvalid) begin
            b_err = exp_empty || (bid != head_id) || (bresp != RESP_OKAY);
        end
    end
endmodule

// File: rtl/axi_wjob_issuer.sv
module axi_wjob_issuer
    import axi_wjob_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold_mode,
    input  logic                job_valid,
    output logic                job_ready,
    input  logic [ADDR_W-1:0]   job_addr,
    input  logic [LEN_W-1:0]    job_len,
    input  logic [ID_W-1:0]     job_id,
    input  logic                byte_valid,
    output logic                byte_ready,
    input  logic [7:0]          byte_data,
    input  logic                byte_last,
    output logic                awvalid,
    input  logic                awready,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [7:0]          awlen,
    output logic [2:0]          awsize,
    output logic [1:0]          awburst,
    output logic [ID_W-1:0]     awid,
    output logic                wvalid,
    input  logic                wready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wlast,
    input  logic                bvalid,
    output logic                bready,
    input  logic [ID_W-1:0]     bid,
    input  logic [1:0]          bresp,
    output logic                err
);
    localparam int BYTES = DATA_W / 8;
    localparam int LG    = $clog2(BYTES);

    wjob_t            aw_q;
    logic             aw_fire;
    logic             lenq_full, lenq_empty, lenq_pop;
    logic [LEN_W-1:0] lenq_head;
    logic             wq_full, wq_empty;
    logic [LEN_W-1:0] wq_head;
    logic             idq_full, b_err;
    logic             burst_done;
    logic [LEN_W-1:0] burst_beats;
    logic             cmp_fire, cmp_err;

    // AW issue: one job register
    assign job_ready = !awvalid && !lenq_full && !idq_full;
    assign aw_fire   = awvalid && awready;

    always_ff @(posedge clk) begin
        if (rst) begin
            awvalid <= 1'b0;
            aw_q    <= '0;
        end else if (job_valid && job_ready) begin
            awvalid <= 1'b1;
            aw_q    <= '{addr: job_addr, len: job_len, id: job_id};
        end else if (aw_fire) begin
            awvalid <= 1'b0;
        end
    end

    assign awaddr  = aw_q.addr;
    assign awid    = aw_q.id;
    assign awlen   = 8'(beats_of(aw_q.len, LG) - 1'b1);
    assign awsize  = 3'(LG);
    assign awburst = BURST_INCR;
    assign bready  = 1'b1;

    // byte lengths of issued bursts, shared by W path and beat compare
    wjob_fifo #(.W(LEN_W), .DEPTH(FIFO_DEPTH)) u_lenq (
        .clk(clk), .rst(rst),
        .push(aw_fire), .din(aw_q.len),
        .pop(lenq_pop), .dout(lenq_head),
        .full(lenq_full), .empty(lenq_empty)
    );

    wjob_packer #(.DATA_W(DATA_W)) u_pack (
        .clk(clk), .rst(rst), .hold_mode(hold_mode),
        .len_known(!lenq_empty), .head_len(lenq_head),
        .byte_valid(byte_valid), .byte_ready(byte_ready),
        .byte_data(byte_data), .byte_last(byte_last),
        .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .wstrb(wstrb), .wlast(wlast),
        .burst_done(burst_done), .burst_beats(burst_beats)
    );

    // lead mode: beat counts of finished bursts, compared with job beats
    wjob_fifo #(.W(LEN_W), .DEPTH(FIFO_DEPTH)) u_wq (
        .clk(clk), .rst(rst),
        .push(!hold_mode && burst_done), .din(burst_beats),
        .pop(cmp_fire), .dout(wq_head),
        .full(wq_full), .empty(wq_empty)
    );

    assign cmp_fire = !hold_mode && !lenq_empty && !wq_empty;
    assign cmp_err  = cmp_fire && (beats_of(lenq_head, LG) != wq_head);
    assign lenq_pop = hold_mode ? burst_done : cmp_fire;

    wjob_bcheck #(.DEPTH(FIFO_DEPTH)) u_bchk (
        .clk(clk), .rst(rst),
        .exp_push(aw_fire), .exp_id(aw_q.id), .exp_full(idq_full),
        .bvalid(bvalid), .bid(bid), .bresp(bresp), .b_err(b_err)
    );

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= err || b_err || cmp_err || (wq_full && burst_done);
    end
endmodule

// File: rtl/axi_wjob_chk.sv
module axi_wjob_chk
    import axi_wjob_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                hold_mode,
    input logic                job_ready,
    input logic                awvalid,
    input logic                awready,
    input logic [ADDR_W-1:0]   awaddr,
    input logic [7:0]          awlen,
    input logic [ID_W-1:0]     awid,
    input logic                wvalid,
    input logic                wready,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W/8-1:0] wstrb,
    input logic                wlast,
    input logic                bvalid,
    input logic [1:0]          bresp,
    input logic                err
);
    logic [7:0] aw_done, w_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_done <= '0;
            w_done  <= '0;
        end else begin
            if (awvalid && awready)         aw_done <= aw_done + 1'b1;
            if (wvalid && wready && wlast)  w_done  <= w_done + 1'b1;
        end
    end

    AST_AW_STABLE: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen) && $stable(awid)); // R2
    AST_ONE_JOB: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> !job_ready); // R3
    AST_STRB_LOW: assert property (@(posedge clk) disable iff (rst)
        wvalid |-> wstrb[0] && ((wstrb & (wstrb + 1'b1)) == '0)); // R5
    AST_STRB_FULL: assert property (@(posedge clk) disable iff (rst)
        wvalid && !wlast |-> (&wstrb)); // R5
    AST_W_STABLE: assert property (@(posedge clk) disable iff (rst)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast)); // R7
    AST_HOLD_ORDER: assert property (@(posedge clk) disable iff (rst)
        hold_mode && wvalid |-> (aw_done != w_done)); // R9
    AST_BAD_RESP: assert property (@(posedge clk) disable iff (rst)
        bvalid && (bresp != RESP_OKAY) |=> err); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R11
endmodule

bind axi_wjob_issuer axi_wjob_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/axi_wjob_issuer_tb.sv
module axi_wjob_issuer_tb;
    import axi_wjob_pkg::*;

    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_mode = 1'b0;
    logic job_valid = 1'b0, job_ready;
    logic [ADDR_W-1:0] job_addr = '0;
    logic [LEN_W-1:0]  job_len = '0;
    logic [ID_W-1:0]   job_id = '0;
    logic byte_valid = 1'b0, byte_ready, byte_last = 1'b0;
    logic [7:0] byte_data = '0;
    logic awvalid, awready = 1'b1;
    logic [ADDR_W-1:0] awaddr;
    logic [7:0] awlen;
    logic [2:0] awsize;
    logic [1:0] awburst;
    logic [ID_W-1:0] awid;
    logic wvalid, wready = 1'b1, wlast;
    logic [DATA_W-1:0] wdata;
    logic [BYTES-1:0]  wstrb;
    logic bvalid = 1'b0, bready;
    logic [ID_W-1:0] bid = '0;
    logic [1:0] bresp = '0;
    logic err;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    axi_wjob_issuer #(.DATA_W(DATA_W), .FIFO_DEPTH(4)) u_dut (.*);

    // handshake logs
    logic [ADDR_W-1:0] aw_addr_l [16];
    logic [7:0]        aw_len_l  [16];
    logic [ID_W-1:0]   aw_id_l   [16];
    logic [2:0]        aw_size_l [16];
    logic [1:0]        aw_brst_l [16];
    logic [DATA_W-1:0] w_data_l  [16];
    logic [BYTES-1:0]  w_strb_l  [16];
    logic              w_last_l  [16];
    int aw_n, w_n;

    always @(posedge clk) begin
        if (rst) begin
            aw_n <= 0;
            w_n  <= 0;
        end else begin
            if (awvalid && awready && aw_n < 16) begin
                aw_addr_l[aw_n] <= awaddr;
                aw_len_l[aw_n]  <= awlen;
                aw_id_l[aw_n]   <= awid;
                aw_size_l[aw_n] <= awsize;
                aw_brst_l[aw_n] <= awburst;
                aw_n <= aw_n + 1;
            end
            if (wvalid && wready && w_n < 16) begin
                w_data_l[w_n] <= wdata;
                w_strb_l[w_n] <= wstrb;
                w_last_l[w_n] <= wlast;
                w_n <= w_n + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic hm);
        @(negedge clk);
        rst = 1'b1; hold_mode = hm;
        job_valid = 0; byte_valid = 0; byte_last = 0; bvalid = 0;
        awready = 1; wready = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_job(input logic [ADDR_W-1:0] a, input int len, input int id);
        @(negedge clk);
        job_valid = 1; job_addr = a; job_len = LEN_W'(len); job_id = ID_W'(id);
        forever begin @(posedge clk); if (job_ready) break; end
        @(negedge clk);
        job_valid = 0;
    endtask

    task automatic send_bytes(input int n, input logic [7:0] base, input int last_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1; byte_data = base + 8'(i); byte_last = (i == last_at);
            forever begin @(posedge clk); if (byte_ready) break; end
        end
        @(negedge clk);
        byte_valid = 0; byte_last = 0;
    endtask

    task automatic send_b(input int id, input logic [1:0] rsp);
        @(negedge clk);
        bvalid = 1; bid = ID_W'(id); bresp = rsp;
        @(negedge clk);
        bvalid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        @(negedge clk);
        chk("R1 awvalid", awvalid, 0);
        chk("R1 wvalid", wvalid, 0);
        chk("R1 err", err, 0);
        chk("R1 job_ready", job_ready, 1);
    endtask

    task automatic t_lead_aligned;
        do_reset(1'b0);
        send_bytes(8, 8'h10, 7);
        idle(4);
        chk("R8 W before job", w_n, 2);
        chk("R8 no AW yet", aw_n, 0);
        send_job(32'h100, 8, 3);
        idle(6);
        chk("R2 awaddr", aw_addr_l[0], 32'h100);
        chk("R2 awlen", aw_len_l[0], 1);
        chk("R2 awsize", aw_size_l[0], 2);
        chk("R2 awburst", aw_brst_l[0], 1);
        chk("R2 awid", aw_id_l[0], 3);
        chk("R4 beat0", w_data_l[0], 32'h13121110);
        chk("R4 beat1", w_data_l[1], 32'h17161514);
        chk("R5 strb0", w_strb_l[0], 4'hF);
        chk("R5 strb1", w_strb_l[1], 4'hF);
        chk("R6 last0", w_last_l[0], 0);
        chk("R6 last1", w_last_l[1], 1);
        chk("R10 match no err", err, 0);
    endtask

    task automatic t_lead_partial;
        do_reset(1'b0);
        send_job(32'h200, 6, 9);
        send_bytes(6, 8'h20, 5);
        idle(6);
        chk("R2 awlen partial", aw_len_l[0], 1);
        chk("R4 beat0", w_data_l[0], 32'h23222120);
        chk("R5 partial data", w_data_l[1], 32'h00002524);
        chk("R5 partial strb", w_strb_l[1], 4'h3);
        chk("R6 last", w_last_l[1], 1);
        chk("R10 no err", err, 0);
    endtask

    task automatic t_hold;
        do_reset(1'b1);
        @(negedge clk);
        byte_valid = 1; byte_data = 8'h30; byte_last = 0;
        idle(4);
        chk("R9 byte_ready held", byte_ready, 0);
        chk("R9 no W", w_n, 0);
        send_job(32'h40, 5, 7);
        send_bytes(5, 8'h30, 1);
        idle(6);
        chk("R9 beats", w_n, 2);
        chk("R9 beat0", w_data_l[0], 32'h33323130);
        chk("R9 last ignored", w_last_l[0], 0);
        chk("R5 hold strb", w_strb_l[1], 4'h1);
        chk("R5 hold data", w_data_l[1], 32'h00000034);
        chk("R6 hold last", w_last_l[1], 1);
        chk("R9 awlen", aw_len_l[0], 1);
        chk("R9 no err", err, 0);
    endtask

    task automatic t_backpressure;
        logic [DATA_W-1:0] d0;
        do_reset(1'b0);
        @(negedge clk);
        wready = 0; awready = 0;
        send_bytes(4, 8'h50, 3);
        idle(1);
        d0 = wdata;
        idle(3);
        chk("R7 wvalid held", wvalid, 1);
        chk("R7 wdata held", wdata, d0);
        chk("R7 byte_ready low", byte_ready, 0);
        send_job(32'h80, 4, 2);
        idle(2);
        chk("R3 awvalid pending", awvalid, 1);
        chk("R3 job_ready low", job_ready, 0);
        chk("R2 awaddr held", awaddr, 32'h80);
        awready = 1; wready = 1;
        idle(4);
        chk("R7 beat after release", w_data_l[0], 32'h53525150);
        chk("R2 one AW", aw_n, 1);
    endtask

    task automatic t_mismatch;
        do_reset(1'b0);
        send_job(32'h0, 4, 1);
        send_bytes(8, 8'h60, 7);
        idle(4);
        chk("R10 beat mismatch err", err, 1);
    endtask

    task automatic t_bresp;
        do_reset(1'b0);
        send_job(32'h0, 4, 5);
        send_bytes(4, 8'h70, 3);
        send_job(32'h10, 4, 6);
        send_bytes(4, 8'h74, 3);
        idle(3);
        send_b(5, 2'b00);
        send_b(6, 2'b00);
        idle(2);
        chk("R11 good B no err", err, 0);
        do_reset(1'b0);
        send_job(32'h0, 4, 2);
        send_bytes(4, 8'h00, 3);
        idle(3);
        send_b(3, 2'b00);
        idle(1);
        chk("R11 wrong bid", err, 1);
        idle(4);
        chk("R11 sticky", err, 1);
        do_reset(1'b0);
        send_job(32'h0, 4, 1);
        send_bytes(4, 8'h00, 3);
        idle(3);
        send_b(1, 2'b10);
        idle(1);
        chk("R11 bad bresp", err, 1);
        do_reset(1'b0);
        send_b(0, 2'b00);
        idle(1);
        chk("R12 unexpected B", err, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_lead_aligned();
                t_lead_partial();
                t_hold();
                t_backpressure();
                t_mismatch();
                t_bresp();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule